// File: doc/BRIEF.md
# PRBS Error Checker with Location Capture

This block checks a serial test stream that arrives one bit per clock, qualified by a valid strobe. It builds its own pseudo-random reference in real time and aligns that reference to the incoming data. First it loads its shift register straight from the received bits. Then it confirms the alignment over a programmable run of matching bits. Once locked, it compares every received bit with the reference. It keeps a running total of compared bits and a running total of disagreements, so that the bit error ratio is the second total divided by the first.

Each disagreement also yields an error location: the value the bit counter held when the bad bit arrived. Locations go into a small FIFO and leave through a ready/valid port, in ascending order. Downstream logic can store them or analyse them as they come. A start pulse begins a new measurement. A run of errors that is too dense inside a 64-bit window means the reference has slipped, so the checker drops lock and aligns itself again.

Top module: `prbs_errloc_checker`

## Requirements
- R1: `poly_sel_i` selects the reference: 0 = x^7+x^6+1, 1 = x^15+x^14+1, 2 = x^31+x^28+1, and 3 behaves as 0. Each bit is predicted as the XOR of the received or predicted bits that lie order and second-tap positions back. Once locked, each valid bit that differs from the prediction counts as exactly one error, and the reference keeps running through errors.
- R2: After a start pulse or a polynomial change, the first `order` valid bits load the reference. Lock then needs N consecutive matching bits, where N = `lock_thr_i`, or 2*order when `lock_thr_i` is 0. `locked_o` is high in the cycle after the Nth match.
- R3: A mismatch during confirmation discards that bit and restarts loading with the next valid bit.
- R4: While locked, each valid bit adds one to `bit_cnt_o` and each error adds one to `err_cnt_o`. Bits received while unlocked change neither counter. Both counters keep their values through a loss of lock and resume after relock.
- R5: Each error pushes the value that `bit_cnt_o` held before that bit into the location FIFO. The first counted bit after a start has index 0, so locations leave in strictly increasing order.
- R6: Locked bits are grouped into back-to-back windows of 64 bits, the first starting at lock. When the error count in the current window exceeds `err_thr_i`, lock is dropped after that bit and loading restarts. That bit and its error are still counted and logged.
- R7: Changing `poly_sel_i` without a start pulse drops lock in the next cycle and leaves all counters unchanged.
- R8: A start pulse clears both counters, the drop counter, the overflow flag and the FIFO, and forces realignment. A bit presented in the same cycle as a start pulse or a polynomial change is discarded.
- R9: The counters stop at all ones. An error on a bit that arrives while `bit_cnt_o` is all ones is counted, but no location is recorded for it.
- R10: The FIFO holds 16 locations. A location produced while the FIFO is full (occupancy taken at the start of the cycle) is dropped. In that case `overflow_o` is set and stays set until the next start pulse, `drop_cnt_o` increments, and `err_cnt_o` still increments.
- R11: `loc_valid_o` is high whenever the FIFO holds an entry. `loc_data_o` stays stable until a cycle with `loc_valid_o` and `loc_ready_i` both high removes that entry.
- R12: After reset, `locked_o`, `loc_valid_o` and `overflow_o` are low and all counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a new measurement: clear and realign |
| poly_sel_i | input | 2 | Reference polynomial select |
| lock_thr_i | input | LOCK_THR_W (6) | Matching bits needed for lock, 0 selects twice the order |
| err_thr_i | input | WERR_W (7) | Allowed errors per 64-bit window before lock is dropped |
| bit_valid_i | input | 1 | Received bit qualifier |
| bit_i | input | 1 | Received bit |
| locked_o | output | 1 | Reference aligned and comparing |
| bit_cnt_o | output | CNT_W (48) | Compared-bit counter |
| err_cnt_o | output | CNT_W (48) | Error counter |
| loc_valid_o | output | 1 | Location available |
| loc_data_o | output | CNT_W (48) | Oldest error location |
| loc_ready_i | input | 1 | Consumer accepts the location |
| overflow_o | output | 1 | A location was dropped on a full FIFO |
| drop_cnt_o | output | CNT_W (48) | Number of dropped locations |

## Verification
A corrupted reference history cannot stay hidden while the input is clean. Within one polynomial order of bits, `err_cnt_o` starts to climb, and soon afterwards `locked_o` falls at the window check. A wrong seeding or confirmation count moves the `locked_o` edge by whole bits, so the bench samples that edge at the exact expected bit count, one short and on the mark. Off-by-one errors in the counters or in the FIFO pointers show up directly in the popped location values, in `drop_cnt_o` and in the cycle where `loc_valid_o` goes low. The bench therefore checks each of those against indices it works out itself.

// File: rtl/prbs_chk_pkg.sv
`timescale 1ns/1ps
package prbs_chk_pkg;

    localparam int HIST_W = 31;

    typedef enum logic [1:0] {
        ST_SEED   = 2'd0,
        ST_VERIFY = 2'd1,
        ST_LOCKED = 2'd2
    } sync_state_e;

    // Order and the two history taps (0-based) of one polynomial.
    typedef struct packed {
        logic [4:0] order;
        logic [4:0] tap_a;
        logic [4:0] tap_b;
    } poly_desc_t;

    // One compare result handed from the aligner to the counters.
    typedef struct packed {
        logic valid;
        logic err;
    } cmp_evt_t;

    function automatic poly_desc_t poly_lookup(input logic [1:0] sel);
        poly_desc_t d;
        case (sel)
            2'd1:    d = '{order: 5'd15, tap_a: 5'd14, tap_b: 5'd13};
            2'd2:    d = '{order: 5'd31, tap_a: 5'd30, tap_b: 5'd27};
            default: d = '{order: 5'd7,  tap_a: 5'd6,  tap_b: 5'd5};
        endcase
        return d;
    endfunction

    function automatic logic [5:0] default_lock_thr(input logic [4:0] order);
        return {order, 1'b0};
    endfunction

endpackage

// File: rtl/prbs_sync_fsm.sv
`timescale 1ns/1ps
module prbs_sync_fsm
    import prbs_chk_pkg::*;
#(
    parameter int LOCK_THR_W = 6,
    parameter int WIN_LEN    = 64,
    localparam int WPOS_W    = $clog2(WIN_LEN),
    localparam int WERR_W    = $clog2(WIN_LEN + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start_i,
    input  logic [1:0]            poly_sel_i,
    input  logic [LOCK_THR_W-1:0] lock_thr_i,
    input  logic [WERR_W-1:0]     err_thr_i,
    input  logic                  bit_valid_i,
    input  logic                  bit_i,
    output logic                  locked_o,
    output cmp_evt_t              evt_o
);

    sync_state_e           state_q;
    logic [1:0]            poly_q;
    logic [HIST_W-1:0]     hist_q;
    logic [4:0]            seed_cnt_q;
    logic [LOCK_THR_W-1:0] match_cnt_q;
    logic [WPOS_W-1:0]     win_pos_q;
    logic [WERR_W-1:0]     win_err_q;

    poly_desc_t            pd;
    logic                  restart;
    logic                  pred;
    logic                  mism;
    logic [LOCK_THR_W-1:0] lock_target;
    logic [WERR_W-1:0]     win_err_inc;
    logic                  err_evt;

    always_comb begin
        pd          = poly_lookup(poly_q);
        restart     = start_i || (poly_sel_i != poly_q);
        pred        = hist_q[pd.tap_a] ^ hist_q[pd.tap_b];
        mism        = bit_i ^ pred;
        lock_target = (lock_thr_i == '0) ? LOCK_THR_W'(default_lock_thr(pd.order))
                                         : lock_thr_i;
        win_err_inc = win_err_q + WERR_W'(mism);
        evt_o.valid = (state_q == ST_LOCKED) && bit_valid_i && !restart;
        evt_o.err   = evt_o.valid && mism;
        err_evt     = evt_o.err;
    end

    assign locked_o = (state_q == ST_LOCKED);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_SEED;
            poly_q      <= 2'd0;
            hist_q      <= '0;
            seed_cnt_q  <= '0;
            match_cnt_q <= '0;
            win_pos_q   <= '0;
            win_err_q   <= '0;
        end else if (restart) begin
            state_q     <= ST_SEED;
            poly_q      <= poly_sel_i;
            seed_cnt_q  <= '0;
            match_cnt_q <= '0;
        end else if (bit_valid_i) begin
            case (state_q)
                ST_SEED: begin
                    hist_q <= {hist_q[HIST_W-2:0], bit_i};
                    if (seed_cnt_q == pd.order - 5'd1) begin
                        state_q     <= ST_VERIFY;
                        match_cnt_q <= '0;
                    end else begin
                        seed_cnt_q <= seed_cnt_q + 5'd1;
                    end
                end
                ST_VERIFY: begin
                    if (mism) begin
                        state_q    <= ST_SEED;
                        seed_cnt_q <= '0;
                    end else begin
                        hist_q <= {hist_q[HIST_W-2:0], bit_i};
                        if (match_cnt_q + LOCK_THR_W'(1) == lock_target) begin
                            state_q   <= ST_LOCKED;
                            win_pos_q <= '0;
                            win_err_q <= '0;
                        end else begin
                            match_cnt_q <= match_cnt_q + LOCK_THR_W'(1);
                        end
                    end
                end
                ST_LOCKED: begin
                    hist_q <= {hist_q[HIST_W-2:0], pred};
                    if (mism && (win_err_inc > err_thr_i)) begin
                        state_q    <= ST_SEED;
                        seed_cnt_q <= '0;
                    end else if (win_pos_q == WPOS_W'(WIN_LEN - 1)) begin
                        win_pos_q <= '0;
                        win_err_q <= '0;
                    end else begin
                        win_pos_q <= win_pos_q + WPOS_W'(1);
                        win_err_q <= win_err_inc;
                    end
                end
                default: state_q <= ST_SEED;
            endcase
        end
    end

    // R2: lock is only entered from confirmation on a matching valid bit
    assert_lock_from_verify_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(locked_o) |-> $past(state_q == ST_VERIFY && bit_valid_i && !mism && !restart));

    // R6 / R7: lock falls only after a counted error or a restart
    assert_unlock_cause_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(locked_o) |-> $past(err_evt || restart));

    // R6: the window error tally never exceeds the window length
    assert_window_bound_R6: assert property (@(posedge clk) disable iff (rst)
        win_err_q <= WERR_W'(WIN_LEN));

endmodule

// File: rtl/prbs_err_stats.sv
`timescale 1ns/1ps
module prbs_err_stats
    import prbs_chk_pkg::*;
#(
    parameter int CNT_W = 48
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear_i,
    input  cmp_evt_t         evt_i,
    input  logic             fifo_full_i,
    output logic             push_o,
    output logic [CNT_W-1:0] push_loc_o,
    output logic [CNT_W-1:0] bit_cnt_o,
    output logic [CNT_W-1:0] err_cnt_o,
    output logic [CNT_W-1:0] drop_cnt_o,
    output logic             overflow_o
);

    logic [CNT_W-1:0] bit_cnt_q, err_cnt_q, drop_cnt_q;
    logic             overflow_q;
    logic             bit_sat, loggable, drop;

    always_comb begin
        bit_sat    = &bit_cnt_q;
        loggable   = evt_i.err && !bit_sat;
        push_o     = loggable && !fifo_full_i;
        drop       = loggable && fifo_full_i;
        push_loc_o = bit_cnt_q;
    end

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            bit_cnt_q  <= '0;
            err_cnt_q  <= '0;
            drop_cnt_q <= '0;
            overflow_q <= 1'b0;
        end else begin
            if (evt_i.valid && !bit_sat)
                bit_cnt_q <= bit_cnt_q + CNT_W'(1);
            if (evt_i.err && !(&err_cnt_q))
                err_cnt_q <= err_cnt_q + CNT_W'(1);
            if (drop && !(&drop_cnt_q))
                drop_cnt_q <= drop_cnt_q + CNT_W'(1);
            if (drop)
                overflow_q <= 1'b1;
        end
    end

    assign bit_cnt_o  = bit_cnt_q;
    assign err_cnt_o  = err_cnt_q;
    assign drop_cnt_o = drop_cnt_q;
    assign overflow_o = overflow_q;

    // R4: without a compared bit the bit counter holds
    assert_hold_unlocked_R4: assert property (@(posedge clk) disable iff (rst)
        (!evt_i.valid && !clear_i) |=> $stable(bit_cnt_q));

    // R9: a saturated bit counter stays saturated until cleared
    assert_saturate_R9: assert property (@(posedge clk) disable iff (rst)
        ((&bit_cnt_q) && !clear_i) |=> (&bit_cnt_q));

    // R1: an error is only reported on a compared bit
    assert_err_needs_valid_R1: assert property (@(posedge clk) disable iff (rst)
        evt_i.err |-> evt_i.valid);

endmodule

// File: rtl/loc_fifo.sv
`timescale 1ns/1ps
module loc_fifo #(
    parameter int DATA_W = 48,
    parameter int DEPTH  = 16,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr_i,
    input  logic              push_i,
    input  logic [DATA_W-1:0] push_data_i,
    output logic              full_o,
    output logic              out_valid_o,
    output logic [DATA_W-1:0] out_data_o,
    input  logic              out_ready_i
);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_q, rd_q;
    logic [AW:0]       cnt_q;
    logic              pop, wr_en;

    always_comb begin
        full_o      = (cnt_q == (AW + 1)'(DEPTH));
        out_valid_o = (cnt_q != '0);
        out_data_o  = mem[rd_q];
        pop         = out_valid_o && out_ready_i;
        wr_en       = push_i && !full_o;
    end

    always_ff @(posedge clk) begin
        if (wr_en)
            mem[wr_q] <= push_data_i;
    end

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (wr_en)
                wr_q <= wr_q + AW'(1);
            if (pop)
                rd_q <= rd_q + AW'(1);
            case ({wr_en, pop})
                2'b10:   cnt_q <= cnt_q + (AW + 1)'(1);
                2'b01:   cnt_q <= cnt_q - (AW + 1)'(1);
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    // R10: the producer never offers a location into a full FIFO
    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (rst)
        !(push_i && full_o));

    // R11: an offered location holds until accepted
    assert_hold_data_R11: assert property (@(posedge clk) disable iff (rst || clr_i)
        (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)));

endmodule

// File: rtl/prbs_errloc_checker.sv
`timescale 1ns/1ps
module prbs_errloc_checker
    import prbs_chk_pkg::*;
#(
    parameter int CNT_W      = 48,
    parameter int LOC_DEPTH  = 16,
    parameter int WIN_LEN    = 64,
    parameter int LOCK_THR_W = 6,
    localparam int WERR_W    = $clog2(WIN_LEN + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start_i,
    input  logic [1:0]            poly_sel_i,
    input  logic [LOCK_THR_W-1:0] lock_thr_i,
    input  logic [WERR_W-1:0]     err_thr_i,
    input  logic                  bit_valid_i,
    input  logic                  bit_i,
    output logic                  locked_o,
    output logic [CNT_W-1:0]      bit_cnt_o,
    output logic [CNT_W-1:0]      err_cnt_o,
    output logic                  loc_valid_o,
    output logic [CNT_W-1:0]      loc_data_o,
    input  logic                  loc_ready_i,
    output logic                  overflow_o,
    output logic [CNT_W-1:0]      drop_cnt_o
);

    cmp_evt_t         evt;
    logic             push;
    logic [CNT_W-1:0] push_loc;
    logic             fifo_full;

    prbs_sync_fsm #(
        .LOCK_THR_W (LOCK_THR_W),
        .WIN_LEN    (WIN_LEN)
    ) u_sync (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .poly_sel_i  (poly_sel_i),
        .lock_thr_i  (lock_thr_i),
        .err_thr_i   (err_thr_i),
        .bit_valid_i (bit_valid_i),
        .bit_i       (bit_i),
        .locked_o    (locked_o),
        .evt_o       (evt)
    );

    prbs_err_stats #(
        .CNT_W (CNT_W)
    ) u_stats (
        .clk         (clk),
        .rst         (rst),
        .clear_i     (start_i),
        .evt_i       (evt),
        .fifo_full_i (fifo_full),
        .push_o      (push),
        .push_loc_o  (push_loc),
        .bit_cnt_o   (bit_cnt_o),
        .err_cnt_o   (err_cnt_o),
        .drop_cnt_o  (drop_cnt_o),
        .overflow_o  (overflow_o)
    );

    loc_fifo #(
        .DATA_W (CNT_W),
        .DEPTH  (LOC_DEPTH)
    ) u_fifo (
        .clk         (clk),
        .rst         (rst),
        .clr_i       (start_i),
        .push_i      (push),
        .push_data_i (push_loc),
        .full_o      (fifo_full),
        .out_valid_o (loc_valid_o),
        .out_data_o  (loc_data_o),
        .out_ready_i (loc_ready_i)
    );

    // R5: a pushed location is the bit index of the bit being counted
    assert_loc_matches_count_R5: assert property (@(posedge clk) disable iff (rst || start_i)
        push |=> (bit_cnt_o == $past(push_loc) + CNT_W'(1)));

    // R8: a start pulse empties the output and clears the counters
    assert_start_clears_R8: assert property (@(posedge clk) disable iff (rst)
        start_i |=> (!loc_valid_o && bit_cnt_o == '0 && err_cnt_o == '0 && !overflow_o));

endmodule

// File: tb/test_prbs_errloc_checker.sv
`timescale 1ns/1ps
module test_prbs_errloc_checker;

    localparam int CW = 10;
    localparam int NV = 6;
    localparam logic [15:0] NONE = 16'hFFFF;
    // poly[47:46] thr[45:40] len[39:32] err_a[31:16] err_b[15:0]
    localparam logic [47:0] VEC [NV] = '{
        {2'd0, 6'd0,  8'd40,  16'd5,  16'd17},
        {2'd1, 6'd0,  8'd50,  16'd0,  16'd49},
        {2'd2, 6'd0,  8'd100, 16'd33, 16'd34},
        {2'd0, 6'd3,  8'd20,  NONE,   NONE},
        {2'd2, 6'd8,  8'd64,  16'd10, 16'd63},
        {2'd3, 6'd5,  8'd30,  16'd29, NONE}
    };

    logic          clk = 1'b0;
    logic          rst, start, bit_valid, bit_in, loc_ready;
    logic [1:0]    poly_sel;
    logic [5:0]    lock_thr;
    logic [6:0]    err_thr;
    logic          locked, loc_valid, overflow;
    logic [CW-1:0] bit_cnt, err_cnt, loc_data, drop_cnt;

    always #5 clk = ~clk;

    prbs_errloc_checker #(.CNT_W(CW)) i_prbs_errloc_checker (
        .clk(clk), .rst(rst), .start_i(start), .poly_sel_i(poly_sel),
        .lock_thr_i(lock_thr), .err_thr_i(err_thr), .bit_valid_i(bit_valid),
        .bit_i(bit_in), .locked_o(locked), .bit_cnt_o(bit_cnt), .err_cnt_o(err_cnt),
        .loc_valid_o(loc_valid), .loc_data_o(loc_data), .loc_ready_i(loc_ready),
        .overflow_o(overflow), .drop_cnt_o(drop_cnt)
    );

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;
    logic [30:0] g = '1;
    logic [1:0]  gpoly = 2'd0;

    function automatic int t_order(input logic [1:0] p);
        return (p == 2'd1) ? 15 : (p == 2'd2) ? 31 : 7;
    endfunction

    function automatic int t_tap2(input logic [1:0] p);
        return (p == 2'd1) ? 14 : (p == 2'd2) ? 28 : 6;
    endfunction

    task automatic chk(input string req, input longint unsigned act, input longint unsigned exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic send(input bit flip);
        int o;
        int s;
        logic nb;
        o = t_order(gpoly);
        s = t_tap2(gpoly);
        nb = g[o-1] ^ g[s-1];
        g = {g[29:0], nb};
        bit_valid = 1'b1;
        bit_in = nb ^ flip;
        @(negedge clk);
        bit_valid = 1'b0;
    endtask

    task automatic send_n(input int n);
        for (int i = 0; i < n; i++) send(1'b0);
    endtask

    task automatic pulse_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic configure(input logic [1:0] p, input logic [5:0] thr, input logic [6:0] ethr);
        poly_sel = p;
        gpoly = p;
        lock_thr = thr;
        err_thr = ethr;
        pulse_start();
    endtask

    task automatic lock_up();
        int o;
        o = t_order(gpoly);
        send_n(o + ((lock_thr == 0) ? 2 * o : int'(lock_thr)));
    endtask

    task automatic pop_chk(input string req, input longint unsigned exp);
        chk(req, loc_valid, 1);
        chk(req, loc_data, exp);
        loc_ready = 1'b1;
        @(negedge clk);
        loc_ready = 1'b0;
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        rst = 1'b1; start = 1'b0; bit_valid = 1'b0; bit_in = 1'b0; loc_ready = 1'b0;
        poly_sel = 2'd0; lock_thr = 6'd0; err_thr = 7'd127;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R12 reset state
        chk("R12 locked", locked, 0);
        chk("R12 loc_valid", loc_valid, 0);
        chk("R12 overflow", overflow, 0);
        chk("R12 bit_cnt", bit_cnt, 0);
        chk("R12 err_cnt", err_cnt, 0);
        chk("R12 drop_cnt", drop_cnt, 0);

        // table walk: R1 R2 R4 R5 R8
        for (int v = 0; v < NV; v++) begin
            logic [1:0]  p;
            logic [5:0]  thr;
            int          len, ea, eb, o, te, ne;
            p   = VEC[v][47:46];
            thr = VEC[v][45:40];
            len = int'(VEC[v][39:32]);
            ea  = int'(VEC[v][31:16]);
            eb  = int'(VEC[v][15:0]);
            configure(p, thr, 7'd127);
            chk("R8 bit_cnt cleared", bit_cnt, 0);
            chk("R8 unlocked after start", locked, 0);
            o  = t_order(p);
            te = (thr == 0) ? 2 * o : int'(thr);
            send_n(o + te - 1);
            chk("R2 one bit short of lock", locked, 0);
            send(1'b0);
            chk("R2 locked on count", locked, 1);
            chk("R4 nothing counted before lock", bit_cnt, 0);
            for (int i = 0; i < len; i++) send((i == ea) || (i == eb));
            ne = ((ea < len) ? 1 : 0) + ((eb < len) ? 1 : 0);
            chk("R4 bit_cnt", bit_cnt, len);
            chk("R1 err_cnt", err_cnt, ne);
            if (ea < len) pop_chk("R5 first location", ea);
            if (eb < len) pop_chk("R5 second location", eb);
            chk("R11 empty after drain", loc_valid, 0);
        end

        // R7 polynomial change without start
        begin
            longint unsigned bc, ec;
            bc = bit_cnt;
            ec = err_cnt;
            poly_sel = 2'd1;
            @(negedge clk);
            chk("R7 lock dropped", locked, 0);
            chk("R7 bit_cnt kept", bit_cnt, bc);
            chk("R7 err_cnt kept", err_cnt, ec);
            gpoly = 2'd1;
            send_n(5);
            chk("R4 unlocked bits not counted", bit_cnt, bc);
        end

        // R3 mismatch during confirmation
        configure(2'd0, 6'd4, 7'd127);
        send_n(9);
        send(1'b1);
        send_n(10);
        chk("R3 reseeding not finished", locked, 0);
        send(1'b0);
        chk("R3 locked after reseed", locked, 1);

        // R6 window loss of lock
        configure(2'd0, 6'd0, 7'd1);
        lock_up();
        for (int i = 0; i < 66; i++) send((i == 63) || (i == 64));
        chk("R6 split across windows keeps lock", locked, 1);
        chk("R6 err_cnt", err_cnt, 2);
        send(1'b1);
        chk("R6 lock lost", locked, 0);
        chk("R6 err counted", err_cnt, 3);
        chk("R6 bit counted", bit_cnt, 67);
        send_n(20);
        chk("R4 held while unlocked", bit_cnt, 67);
        chk("R2 relock not yet", locked, 0);
        send(1'b0);
        chk("R2 relocked", locked, 1);
        send(1'b0);
        chk("R4 resumes after relock", bit_cnt, 68);

        // R8 start clears a non-empty state
        chk("R8 fifo holds locations", loc_valid, 1);
        pulse_start();
        chk("R8 fifo cleared", loc_valid, 0);
        chk("R8 bit_cnt cleared", bit_cnt, 0);
        chk("R8 err_cnt cleared", err_cnt, 0);
        chk("R8 locked cleared", locked, 0);

        // R10 R11 overflow and handshake
        configure(2'd0, 6'd0, 7'd127);
        lock_up();
        for (int i = 0; i < 36; i++) send((i % 2) == 0);
        chk("R10 err_cnt incl dropped", err_cnt, 18);
        chk("R10 drop_cnt", drop_cnt, 2);
        chk("R10 overflow set", overflow, 1);
        chk("R11 valid", loc_valid, 1);
        chk("R11 head", loc_data, 0);
        repeat (2) @(negedge clk);
        chk("R11 head stable", loc_data, 0);
        for (int k = 0; k < 16; k++) pop_chk("R11 drain order", 2 * k);
        chk("R10 empty after 16", loc_valid, 0);
        chk("R10 overflow sticky", overflow, 1);
        pulse_start();
        chk("R8 overflow cleared", overflow, 0);
        chk("R8 drop_cnt cleared", drop_cnt, 0);

        // R9 saturation
        configure(2'd0, 6'd0, 7'd127);
        lock_up();
        for (int i = 0; i < 1030; i++) send((i == 1022) || (i == 1026));
        chk("R9 bit_cnt saturated", bit_cnt, 1023);
        chk("R9 err_cnt", err_cnt, 2);
        pop_chk("R9 location before saturation", 1022);
        chk("R9 no location after saturation", loc_valid, 0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule